// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller

This block gathers 32 interrupt request lines into one pending-status register and presents two summary interrupt outputs, a normal one and a critical one. Each source can be set up on its own as a level or edge input, with either polarity. A detected event is latched into a status bit. An enable register gates the status into a masked view, and a per-source select steers each enabled, pending source to one of the two outputs. Software clears status bits by writing ones. A level source that is still at its active level cannot be cleared.

Software reaches the block through a simple word-addressed register port. Reads are combinational from the address, and a write takes effect on the rising clock edge while the write enable is high. Source n is held in register bit 31−n in every per-source register, so source 0 is the most significant bit. The vector and vector-configuration words are decoded but hold nothing. The output of one controller can be wired to an input of another, which gives a simple cascade.

The bus decode uses an enumerated register select. There is no sequencing state machine, because every register updates in a single cycle.

Top module: `irq_ctrl32`

## Requirements
- R1: Source n (input `src_i[n]`) is held in bit 31−n of the status, enable, critical-select, polarity, trigger and masked-status registers.
- R2: Word offsets are: status 0x0, enable 0x2, critical select 0x3, polarity 0x4, trigger 0x5, masked status 0x6, vector 0x7, vector configuration 0x8. The enable, critical-select, polarity and trigger words read back the last value written to them.
- R3: Each input passes through two synchronizing flops. A level source that goes active while its input is set up before rising edge A shows in the status on the third rising edge counted from A, and not before.
- R4: A trigger bit of 0 selects level sensing. The status bit is then set on every cycle in which the synchronized input matches the polarity bit: 1 means active high, 0 means active low.
- R5: A trigger bit of 1 selects edge sensing. Polarity 1 means a rising edge and polarity 0 means a falling edge, each detected against the previous cycle's synchronized value. A detected edge sets the status bit, and the bit stays set after the input returns, whatever the value of the enable bit.
- R6: Writing the status word clears every bit written as 1 and leaves every bit written as 0 unchanged. Writing all ones clears every latched edge event.
- R7: A level source whose input is still active keeps its status bit set through a clear write, whether its enable bit is 1 or 0.
- R8: When a set condition and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R9: The masked-status word reads as status AND enable. It is read-only, and writes to it change nothing.
- R10: The normal output is the OR of the masked-status bits whose critical-select bit is 0. The critical output is the OR of the masked-status bits whose critical-select bit is 1. Both outputs are 0 when the masked status is zero.
- R11: During reset, every register reads 0 and both outputs are 0.
- R12: The vector word, the vector-configuration word and the undecoded offsets 0x1 and 0x9–0xF read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt request lines, asynchronous; bit n is source n |
| bus_addr | input | 4 | Register word offset |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_norm_o | output | 1 | Normal interrupt output |
| irq_crit_o | output | 1 | Critical interrupt output |

## Verification
The bench targets these corner cases:
- Bit order. A design that put source n at bit n would show source 0 in the least significant bit.
- Synchronizer latency. A short or missing synchronizer stage would make a level source appear one or two cycles early.
- A clear write landing in the same cycle as a new edge. A clear-first design would silently lose that interrupt.
- A clear issued while a level input is still active. It must not stick, even with the source disabled.
- Writes aimed at the masked-status word, the vector words and the undecoded offsets. None of them may alter state.
- Long stretches of random source activity and random writes. These are compared cycle by cycle against a behavioural model, which exposes any swapped polarity sense, any edge detector built on the raw input, and any output routed to the wrong line.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Word offsets of the register map
    localparam int OFF_STAT = 0;
    localparam int OFF_EN   = 2;
    localparam int OFF_CRIT = 3;
    localparam int OFF_POL  = 4;
    localparam int OFF_TRIG = 5;
    localparam int OFF_MSK  = 6;
    localparam int OFF_VEC  = 7;
    localparam int OFF_VCFG = 8;

    typedef enum logic [3:0] {
        SEL_STAT,
        SEL_EN,
        SEL_CRIT,
        SEL_POL,
        SEL_TRIG,
        SEL_MSK,
        SEL_VEC,
        SEL_VCFG,
        SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/irqc_src_cell.sv
module irqc_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic trig_i,
    input  logic pol_i,
    input  logic clr_i,
    output logic stat_o
);

    logic act;
    logic prev_q;
    logic hit;
    logic stat_q;

    // Polarity-adjusted input: 1 while the source is at its active sense
    assign act = sync_i ~^ pol_i;
    assign hit = trig_i ? (act & ~prev_q) : act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            prev_q <= act;
            stat_q <= hit | (stat_q & ~clr_i);
        end
    end

    assign stat_o = stat_q;

    assert_level_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_i && act) |=> stat_q);

    assert_edge_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !clr_i) |=> stat_q);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && act && !prev_q && clr_i) |=> stat_q);

endmodule

// File: rtl/irq_ctrl32.sv
module irq_ctrl32
    import irqc_pkg::*;
#(
    parameter int IRQ_W       = 32,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IRQ_W-1:0]  src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [IRQ_W-1:0]  bus_wdata,
    output logic [IRQ_W-1:0]  bus_rdata,
    output logic              irq_norm_o,
    output logic              irq_crit_o
);

    localparam int MSB = IRQ_W - 1;

    reg_sel_e         sel;
    logic [IRQ_W-1:0] sync_q;
    logic [IRQ_W-1:0] en_q, crit_q, pol_q, trig_q;
    logic [IRQ_W-1:0] stat;
    logic [IRQ_W-1:0] clr;
    logic [IRQ_W-1:0] masked;

    // Address decode
    always_comb begin
        unique case (int'(bus_addr))
            OFF_STAT: sel = SEL_STAT;
            OFF_EN:   sel = SEL_EN;
            OFF_CRIT: sel = SEL_CRIT;
            OFF_POL:  sel = SEL_POL;
            OFF_TRIG: sel = SEL_TRIG;
            OFF_MSK:  sel = SEL_MSK;
            OFF_VEC:  sel = SEL_VEC;
            OFF_VCFG: sel = SEL_VCFG;
            default:  sel = SEL_NONE;
        endcase
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            crit_q <= '0;
            pol_q  <= '0;
            trig_q <= '0;
        end else if (bus_we) begin
            unique case (sel)
                SEL_EN:   en_q   <= bus_wdata;
                SEL_CRIT: crit_q <= bus_wdata;
                SEL_POL:  pol_q  <= bus_wdata;
                SEL_TRIG: trig_q <= bus_wdata;
                default:  ;
            endcase
        end
    end

    assign clr = (bus_we && sel == SEL_STAT) ? bus_wdata : '0;

    irqc_sync #(
        .WIDTH  (IRQ_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (src_i),
        .q_o   (sync_q)
    );

    // One cell per source; source n sits at register bit MSB-n
    for (genvar n = 0; n < IRQ_W; n++) begin : g_src
        irqc_src_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .sync_i (sync_q[n]),
            .trig_i (trig_q[MSB-n]),
            .pol_i  (pol_q[MSB-n]),
            .clr_i  (clr[MSB-n]),
            .stat_o (stat[MSB-n])
        );
    end

    assign masked     = stat & en_q;
    assign irq_norm_o = |(masked & ~crit_q);
    assign irq_crit_o = |(masked & crit_q);

    // Read mux
    always_comb begin
        unique case (sel)
            SEL_STAT: bus_rdata = stat;
            SEL_EN:   bus_rdata = en_q;
            SEL_CRIT: bus_rdata = crit_q;
            SEL_POL:  bus_rdata = pol_q;
            SEL_TRIG: bus_rdata = trig_q;
            SEL_MSK:  bus_rdata = masked;
            default:  bus_rdata = '0;
        endcase
    end

    assert_quiet_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (masked == '0) |-> (!irq_norm_o && !irq_crit_o));

    assert_single_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(stat & en_q) == 1) |-> (irq_norm_o != irq_crit_o));

endmodule

// File: tb/irq_ctrl32_bench.sv
`timescale 1ns/1ps
module irq_ctrl32_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src;
    logic [3:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq_n, irq_c;

    int checks = 0;
    int fails  = 0;
    bit mon_en = 1'b0;

    always #2.5 clk = ~clk;

    irq_ctrl32 u_irq_ctrl32 (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src),
        .bus_addr   (addr),
        .bus_we     (we),
        .bus_wdata  (wdata),
        .bus_rdata  (rdata),
        .irq_norm_o (irq_n),
        .irq_crit_o (irq_c)
    );

    // Behavioural reference model (register-bit space for words)
    logic [31:0] m_en, m_crit, m_pol, m_trig, m_stat;
    bit          m_s1 [32];
    bit          m_s2 [32];
    bit          m_prev [32];

    always @(posedge clk) begin : model
        logic [31:0] n_stat;
        bit          a, hit, c;
        if (!rst_n) begin
            m_en = 0; m_crit = 0; m_pol = 0; m_trig = 0; m_stat = 0;
            for (int n = 0; n < 32; n++) begin
                m_s1[n] = 0; m_s2[n] = 0; m_prev[n] = 0;
            end
        end else begin
            for (int n = 0; n < 32; n++) begin
                a   = m_pol[31-n] ? m_s2[n] : !m_s2[n];
                hit = m_trig[31-n] ? (a && !m_prev[n]) : a;
                c   = we && addr == 4'h0 && wdata[31-n];
                n_stat[31-n] = hit || (m_stat[31-n] && !c);
                m_prev[n] = a;
                m_s2[n]   = m_s1[n];
                m_s1[n]   = src[n];
            end
            m_stat = n_stat;
            if (we) begin
                case (addr)
                    4'h2: m_en   = wdata;
                    4'h3: m_crit = wdata;
                    4'h4: m_pol  = wdata;
                    4'h5: m_trig = wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'h0: return m_stat;
            4'h2: return m_en;
            4'h3: return m_crit;
            4'h4: return m_pol;
            4'h5: return m_trig;
            4'h6: return m_stat & m_en;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_for(input logic [3:0] a);
        case (a)
            4'h0: return "R6";
            4'h2, 4'h3, 4'h4, 4'h5: return "R2";
            4'h6: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_en) begin
                chk(tag_for(addr), rdata, m_read(addr));
                chk("R10", {30'b0, irq_n, irq_c},
                    {30'b0, |(m_stat & m_en & ~m_crit), |(m_stat & m_en & m_crit)});
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_expect(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a; we = 1'b0;
        @(posedge clk);
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    bit done = 1'b0;

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; src = 32'h0; addr = 4'h0; we = 1'b0; wdata = 32'h0;
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        for (int a = 0; a < 16; a++) begin
            addr = 4'(a);
            #0.1;
            chk("R11", rdata, 32'h0);
        end
        chk("R11", {30'b0, irq_n, irq_c}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;

        // Edge mode, rising, all sources; clear leftover level events
        wr(4'h4, 32'hFFFF_FFFF);
        wr(4'h5, 32'hFFFF_FFFF);
        cyc(4);
        wr(4'h0, 32'hFFFF_FFFF);
        rd_expect(4'h0, 32'h0, "R6");

        // R1 / R5: source 0 rising edge lands in bit 31 and sticks
        @(negedge clk); src[0] = 1'b1;
        cyc(3);
        rd_expect(4'h0, 32'h8000_0000, "R1");
        @(negedge clk); src[0] = 1'b0;
        cyc(4);
        rd_expect(4'h0, 32'h8000_0000, "R5");

        // R9 / R10: masked view and normal routing
        wr(4'h2, 32'h8000_0000);
        rd_expect(4'h6, 32'h8000_0000, "R9");
        chk("R10", {31'b0, irq_n}, 32'h1);
        chk("R10", {31'b0, irq_c}, 32'h0);
        wr(4'h6, 32'h0);
        rd_expect(4'h6, 32'h8000_0000, "R9");

        // R10: critical routing
        wr(4'h3, 32'h8000_0000);
        rd_expect(4'h6, 32'h8000_0000, "R10");
        chk("R10", {30'b0, irq_n, irq_c}, 32'h1);

        // R6: zeros keep, ones clear
        wr(4'h0, 32'h7FFF_FFFF);
        rd_expect(4'h0, 32'h8000_0000, "R6");
        wr(4'h0, 32'h8000_0000);
        rd_expect(4'h0, 32'h0, "R6");
        chk("R10", {30'b0, irq_n, irq_c}, 32'h0);

        // R4 / R7: source 5 (bit 26) level active low, disabled
        wr(4'h5, 32'hFBFF_FFFF);
        wr(4'h4, 32'hFBFF_FFFF);
        cyc(3);
        rd_expect(4'h0, 32'h0400_0000, "R4");
        wr(4'h0, 32'h0400_0000);
        rd_expect(4'h0, 32'h0400_0000, "R7");
        @(negedge clk); src[5] = 1'b1;
        cyc(4);
        wr(4'h0, 32'h0400_0000);
        rd_expect(4'h0, 32'h0, "R4");

        // R8: edge on source 1 (bit 30) meets a clear in the same cycle
        @(negedge clk); src[1] = 1'b1; addr = 4'h0;
        @(negedge clk);
        @(negedge clk);
        wdata = 32'h4000_0000; we = 1'b1;
        @(posedge clk);
        #1;
        chk("R8", rdata & 32'h4000_0000, 32'h4000_0000);
        @(negedge clk); we = 1'b0;
        wr(4'h0, 32'h4000_0000);
        rd_expect(4'h0, 32'h0, "R6");

        // R3: source 2 (bit 29) level high, latency of three edges
        wr(4'h5, 32'hDBFF_FFFF);
        @(negedge clk); src[2] = 1'b1; addr = 4'h0; we = 1'b0;
        @(posedge clk); #1;
        chk("R3", rdata & 32'h2000_0000, 32'h0);
        @(posedge clk); #1;
        chk("R3", rdata & 32'h2000_0000, 32'h0);
        @(posedge clk); #1;
        chk("R3", rdata & 32'h2000_0000, 32'h2000_0000);

        // R2 / R12: readback and dead offsets
        wr(4'h2, 32'h1234_5678);
        rd_expect(4'h2, 32'h1234_5678, "R2");
        wr(4'h1, 32'hFFFF_FFFF);
        wr(4'h7, 32'hFFFF_FFFF);
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'h9, 32'hFFFF_FFFF);
        wr(4'hF, 32'hFFFF_FFFF);
        rd_expect(4'h1, 32'h0, "R12");
        rd_expect(4'h7, 32'h0, "R12");
        rd_expect(4'h8, 32'h0, "R12");
        rd_expect(4'hF, 32'h0, "R12");
        rd_expect(4'h2, 32'h1234_5678, "R12");
        rd_expect(4'h3, 32'h8000_0000, "R12");

        // Random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) src = $urandom();
            else if ($urandom_range(0, 1) == 0) src[$urandom_range(0, 31)] ^= 1'b1;
            addr  = 4'($urandom_range(0, 15));
            we    = ($urandom_range(0, 3) == 0);
            wdata = $urandom();
        end
        @(negedge clk); we = 1'b0;
        cyc(2);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule